// File: doc/BRIEF.md
# Interrupt Acknowledge Bus Sequencer

This block drives the bus side of an interrupt acknowledge once the core has decided to take an interrupt. A request starts a locked exchange of two acknowledge bus cycles. Each bus cycle opens with a single status state and then runs command states, which repeat until the ready input reports that the responder is ready. A fixed run of idle states separates the two cycles.

Every bus state lasts two clocks, which are called phase 1 and phase 2. State changes happen only at the clock edge that ends phase 2. The block asserts the bus lock for the whole exchange, so no other master can win the bus between the two cycles. It keeps the address outputs floated until late in the second cycle. Whatever the bus carries in the first cycle is discarded. The vector is taken from the data bus only in the command state of the second cycle in which ready is accepted. A valid strobe then marks the vector for one bus state, after which the sequencer returns to idle and releases the lock.

Top module: `intack_seq`

## Requirements
- R1: Each accepted request produces exactly two acknowledge bus cycles. Each cycle's status state shows `stat_o` = 2'b00 for two clocks, so one exchange shows that code for 4 clocks in total. At all other times `stat_o` = 2'b11.
- R2: A bus state spans two clocks: phase 1, then phase 2. After reset the first clock is phase 1. Every cycle is one status state followed directly by one or more command states.
- R3: Between the last command state of the first cycle and the status state of the second there are exactly IDLE_GAP (default 3) idle states, which is 6 clocks. During these clocks `inta_n_o` = 1, `stat_o` = 2'b11 and `lock_n_o` = 0.
- R4: Data on `data_i` during the first cycle, and at any time other than the accepting command state of the second cycle, leaves `vec_o` unchanged.
- R5: `vec_o` loads `data_i` as sampled at the clock edge that ends phase 2 of the first command state of the second cycle in which `rdy_i` = 1 is accepted.
- R6: `lock_n_o` is 0 from the first status state through the valid state, and 1 only while idle.
- R7: `addr_en_o` is 0 from the first status state up to and including phase 1 of the second command state of the second cycle. It is 1 from phase 2 of that state onward, and whenever the sequencer is idle.
- R8: `rdy_i` is ignored in the first MIN_WAIT (default 1) command states of each cycle. With `rdy_i` held at 1, each cycle therefore has exactly two command states (4 clocks).
- R9: `inta_n_o` is 0 exactly during command states and 1 during status, idle and valid states.
- R10: `vec_vld_o` is 1 for exactly one bus state (2 clocks), starting right after capture. The sequencer is idle in the following state.
- R11: `req_i` is sampled only at the edge ending phase 2 of an idle state. A request at any other time, including any time while busy, is ignored.
- R12: While `rst_n` = 0 and just after it, the outputs are `stat_o` = 2'b11, `inta_n_o` = 1, `lock_n_o` = 1, `addr_en_o` = 1, `vec_o` = 0 and `vec_vld_o` = 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock; two clocks form one bus state |
| rst_n | input | 1 | Synchronous active-low reset |
| req_i | input | 1 | Interrupt accepted, start an acknowledge exchange |
| rdy_i | input | 1 | Responder ready (1 = ready) |
| data_i | input | DATA_W | Data bus |
| stat_o | output | 2 | Bus status code: 2'b00 in acknowledge status states, 2'b11 otherwise |
| inta_n_o | output | 1 | Acknowledge strobe, active low |
| lock_n_o | output | 1 | Bus lock, active low |
| addr_en_o | output | 1 | Address and byte-high outputs driven when 1 |
| vec_o | output | DATA_W | Captured interrupt vector |
| vec_vld_o | output | 1 | Vector valid, one bus state |

## Verification
Two things can collide at the phase-2 edge of a command state: the minimum-wait rule and ready acceptance. When they do, `rdy_i` = 1 arrives in the first command state and must be refused. The bench provokes this by holding ready high through a whole exchange, and checks that each cycle still has exactly two command states. A second collision is a new request arriving in the same edge or state in which the sequencer leaves its valid state. The bench provokes it with a held request and with random request pulses. A reference model that steps bus states behaviourally checks every output on every clock.

// File: rtl/intack_pkg.sv
// Shared types for the interrupt acknowledge sequencer.
// Assumes: one bus state = two clocks; encodings used by all submodules.
package intack_pkg;
    typedef enum logic [2:0] {
        SQ_IDLE  = 3'd0,
        SQ_STAT1 = 3'd1,
        SQ_CMD1  = 3'd2,
        SQ_GAP   = 3'd3,
        SQ_STAT2 = 3'd4,
        SQ_CMD2  = 3'd5,
        SQ_DONE  = 3'd6
    } seq_st_e;

    localparam logic [1:0] STAT_ACK     = 2'b00;
    localparam logic [1:0] STAT_PASSIVE = 2'b11;
endpackage

// File: rtl/intack_phase.sv
// Phase generator: splits the clock into two-clock bus states.
// Assumes: reset puts the first clock after reset into phase 1.
module intack_phase (
    input  logic clk,
    input  logic rst_n,
    output logic ph2_o
);
    logic ph_q;

    // Toggle the phase every clock; 0 = phase 1, 1 = phase 2.
    always_ff @(posedge clk) begin
        if (!rst_n) ph_q <= 1'b0;
        else        ph_q <= ~ph_q;
    end

    assign ph2_o = ph_q;

    AST_PHASE_ALT_A: assert property (@(posedge clk) disable iff (!rst_n)
        ph_q |=> !ph_q); // R2
    AST_PHASE_ALT_B: assert property (@(posedge clk) disable iff (!rst_n)
        !ph_q |=> ph_q); // R2
endmodule

// File: rtl/intack_fsm.sv
// Bus-state sequencer for the locked two-cycle acknowledge exchange.
// Assumes: state_end_i is high on the phase-2 clock of each bus state;
// the wait counter saturates and is only compared against small values.
module intack_fsm
    import intack_pkg::*;
#(
    parameter int IDLE_GAP = 3,
    parameter int MIN_WAIT = 1,
    localparam int SAT     = MIN_WAIT + 2,
    localparam int CNT_W   = $clog2(SAT + 1),
    localparam int GAP_W   = (IDLE_GAP > 1) ? $clog2(IDLE_GAP) : 1
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             state_end_i,
    input  logic             req_i,
    input  logic             rdy_i,
    output seq_st_e          st_o,
    output logic [CNT_W-1:0] cmd_idx_o,
    output logic             cap_o
);
    localparam logic [CNT_W-1:0] IDX_SAT  = CNT_W'(SAT);
    localparam logic [CNT_W-1:0] IDX_MIN  = CNT_W'(MIN_WAIT);
    localparam logic [GAP_W-1:0] GAP_LAST = GAP_W'(IDLE_GAP - 1);

    seq_st_e          st_q, st_d;
    logic [CNT_W-1:0] idx_q, idx_d;
    logic [GAP_W-1:0] gap_q, gap_d;
    logic             in_cmd;
    logic             accept;

    // Command state finishes when ready is seen after the minimum waits.
    always_comb begin
        in_cmd = (st_q == SQ_CMD1) || (st_q == SQ_CMD2);
        accept = state_end_i && in_cmd && rdy_i && (idx_q >= IDX_MIN);
    end

    // Next-state, wait-index and gap-count logic, evaluated per bus state.
    always_comb begin
        st_d  = st_q;
        idx_d = idx_q;
        gap_d = gap_q;
        if (state_end_i) begin
            unique case (st_q)
                SQ_IDLE:  if (req_i) st_d = SQ_STAT1;
                SQ_STAT1: begin st_d = SQ_CMD1; idx_d = '0; end
                SQ_CMD1: begin
                    if (accept) begin
                        st_d  = SQ_GAP;
                        gap_d = '0;
                    end else if (idx_q != IDX_SAT) begin
                        idx_d = idx_q + 1'b1;
                    end
                end
                SQ_GAP: begin
                    if (gap_q == GAP_LAST) st_d = SQ_STAT2;
                    else                   gap_d = gap_q + 1'b1;
                end
                SQ_STAT2: begin st_d = SQ_CMD2; idx_d = '0; end
                SQ_CMD2: begin
                    if (accept)                 st_d  = SQ_DONE;
                    else if (idx_q != IDX_SAT)  idx_d = idx_q + 1'b1;
                end
                SQ_DONE:  st_d = SQ_IDLE;
                default:  st_d = SQ_IDLE;
            endcase
        end
    end

    // State registers.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q  <= SQ_IDLE;
            idx_q <= '0;
            gap_q <= '0;
        end else begin
            st_q  <= st_d;
            idx_q <= idx_d;
            gap_q <= gap_d;
        end
    end

    assign st_o      = st_q;
    assign cmd_idx_o = idx_q;
    assign cap_o     = accept && (st_q == SQ_CMD2);

    AST_STATE_ON_PH2: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q != $past(st_q)) |-> $past(state_end_i)); // R2
    AST_EARLY_READY: assert property (@(posedge clk) disable iff (!rst_n)
        (in_cmd && state_end_i && (idx_q < IDX_MIN)) |=> (st_q == $past(st_q))); // R8
    AST_START_FROM_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        ((st_q == SQ_STAT1) && ($past(st_q) != SQ_STAT1)) |-> ($past(st_q) == SQ_IDLE)); // R11
    AST_GAP_TO_STAT2: assert property (@(posedge clk) disable iff (!rst_n)
        ((st_q == SQ_STAT2) && ($past(st_q) != SQ_STAT2)) |-> ($past(st_q) == SQ_GAP)); // R3
endmodule

// File: rtl/intack_vec.sv
// Vector register: loads the data bus only on the capture strobe.
// Assumes: cap_i is a single-clock pulse from the sequencer.
module intack_vec #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap_i,
    input  logic [DATA_W-1:0] data_i,
    output logic [DATA_W-1:0] vec_o
);
    logic [DATA_W-1:0] vec_q;

    // Hold the vector; replace it only on capture.
    always_ff @(posedge clk) begin
        if (!rst_n)     vec_q <= '0;
        else if (cap_i) vec_q <= data_i;
    end

    assign vec_o = vec_q;

    AST_VEC_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        !cap_i |=> $stable(vec_q)); // R4
endmodule

// File: rtl/intack_seq.sv
// Top of the interrupt acknowledge sequencer: phase generator,
// bus-state sequencer, vector register and output decode.
// Assumes: rdy_i and data_i are synchronous to clk.
module intack_seq
    import intack_pkg::*;
#(
    parameter int DATA_W   = 16,
    parameter int IDLE_GAP = 3,
    parameter int MIN_WAIT = 1,
    localparam int CNT_W   = $clog2(MIN_WAIT + 3)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_i,
    input  logic              rdy_i,
    input  logic [DATA_W-1:0] data_i,
    output logic [1:0]        stat_o,
    output logic              inta_n_o,
    output logic              lock_n_o,
    output logic              addr_en_o,
    output logic [DATA_W-1:0] vec_o,
    output logic              vec_vld_o
);
    logic             ph2;
    seq_st_e          st;
    logic [CNT_W-1:0] cmd_idx;
    logic             cap;
    logic             addr_late;

    intack_phase u_phase (
        .clk   (clk),
        .rst_n (rst_n),
        .ph2_o (ph2)
    );

    intack_fsm #(
        .IDLE_GAP (IDLE_GAP),
        .MIN_WAIT (MIN_WAIT)
    ) u_fsm (
        .clk         (clk),
        .rst_n       (rst_n),
        .state_end_i (ph2),
        .req_i       (req_i),
        .rdy_i       (rdy_i),
        .st_o        (st),
        .cmd_idx_o   (cmd_idx),
        .cap_o       (cap)
    );

    intack_vec #(
        .DATA_W (DATA_W)
    ) u_vec (
        .clk    (clk),
        .rst_n  (rst_n),
        .cap_i  (cap),
        .data_i (data_i),
        .vec_o  (vec_o)
    );

    // Decode bus pins from the sequencer state and phase.
    always_comb begin
        addr_late = (cmd_idx >= CNT_W'(2)) || ((cmd_idx == CNT_W'(1)) && ph2);
        stat_o    = ((st == SQ_STAT1) || (st == SQ_STAT2)) ? STAT_ACK : STAT_PASSIVE;
        inta_n_o  = !((st == SQ_CMD1) || (st == SQ_CMD2));
        lock_n_o  = (st == SQ_IDLE);
        vec_vld_o = (st == SQ_DONE);
        unique case (st)
            SQ_IDLE, SQ_DONE: addr_en_o = 1'b1;
            SQ_CMD2:          addr_en_o = addr_late;
            default:          addr_en_o = 1'b0;
        endcase
    end

    AST_LOCK_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(lock_n_o) |-> $past(vec_vld_o)); // R6
    AST_STROBE_NOT_IN_STATUS: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_o == STAT_ACK) |-> inta_n_o); // R9
    AST_ADDR_UNDER_LOCK: assert property (@(posedge clk) disable iff (!rst_n)
        !addr_en_o |-> !lock_n_o); // R7
    AST_VLD_TWO_CLOCKS: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(vec_vld_o) |=> vec_vld_o); // R10
endmodule

// File: tb/intack_seq_tb.sv
`timescale 1ns/1ps
module intack_seq_tb;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_i = 1'b0;
    logic        rdy_i = 1'b0;
    logic [15:0] data_i = 16'h0;
    logic [1:0]  stat_o;
    logic        inta_n_o, lock_n_o, addr_en_o, vec_vld_o;
    logic [15:0] vec_o;

    int checks = 0;
    int errors = 0;
    bit finished = 0;

    always #2.5 clk = ~clk;

    intack_seq u_dut (
        .clk(clk), .rst_n(rst_n), .req_i(req_i), .rdy_i(rdy_i), .data_i(data_i),
        .stat_o(stat_o), .inta_n_o(inta_n_o), .lock_n_o(lock_n_o),
        .addr_en_o(addr_en_o), .vec_o(vec_o), .vec_vld_o(vec_vld_o)
    );

    // Behavioural reference: bus state number, phase, wait count, gap count.
    int          m_ph, m_st, m_idx, m_gap;
    logic [15:0] m_vec;
    always @(posedge clk) begin
        if (!rst_n) begin
            m_ph = 0; m_st = 0; m_idx = 0; m_gap = 0; m_vec = 0;
        end else begin
            bit fin;
            fin = (m_ph == 1);
            m_ph = 1 - m_ph;
            if (fin) begin
                case (m_st)
                    0: if (req_i) m_st = 1;
                    1: begin m_st = 2; m_idx = 0; end
                    2: if (rdy_i && m_idx >= 1) begin m_st = 3; m_gap = 0; end
                       else if (m_idx < 3) m_idx++;
                    3: if (m_gap == 2) m_st = 4; else m_gap++;
                    4: begin m_st = 5; m_idx = 0; end
                    5: if (rdy_i && m_idx >= 1) begin m_st = 6; m_vec = data_i; end
                       else if (m_idx < 3) m_idx++;
                    default: m_st = 0;
                endcase
            end
        end
    end

    task automatic chk(input string tag, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h at %0t", tag, act, exp, $time);
        end
    endtask

    // Per-clock comparison of every output against the model.
    bit run_cmp = 0;
    always @(negedge clk) begin
        if (run_cmp && rst_n) begin
            chk("R1 R2 R11 stat", stat_o, (m_st == 1 || m_st == 4) ? 0 : 3);
            chk("R9 inta_n", inta_n_o, (m_st == 2 || m_st == 5) ? 0 : 1);
            chk("R6 R11 lock_n", lock_n_o, (m_st == 0) ? 1 : 0);
            chk("R7 addr_en", addr_en_o,
                (m_st == 0 || m_st == 6 ||
                 (m_st == 5 && (m_idx >= 2 || (m_idx == 1 && m_ph == 1)))) ? 1 : 0);
            chk("R4 R5 vec", vec_o, m_vec);
            chk("R10 vec_vld", vec_vld_o, (m_st == 6) ? 1 : 0);
        end
    end

    // Port-level monitor: status clocks, idle gap and command lengths.
    int  ts_clks = 0, gap_clks = 0, tc1 = 0, tc2 = 0;
    bit  prev_vld = 0;
    bit  fast_mode = 0;
    always @(negedge clk) begin
        if (!rst_n) begin
            ts_clks = 0; gap_clks = 0; tc1 = 0; tc2 = 0; prev_vld = 0;
        end else begin
            if (stat_o == 2'b00) ts_clks++;
            if (!inta_n_o && ts_clks == 2) tc1++;
            if (!inta_n_o && ts_clks == 4) tc2++;
            if (ts_clks == 2 && tc1 > 0 && inta_n_o && !lock_n_o && stat_o == 2'b11)
                gap_clks++;
            if (vec_vld_o && !prev_vld) begin
                chk("R1 status clocks per exchange", ts_clks, 4);
                chk("R3 idle gap clocks", gap_clks, 6);
                if (fast_mode) begin
                    chk("R8 first cycle command clocks", tc1, 4);
                    chk("R8 second cycle command clocks", tc2, 4);
                end
                ts_clks = 0; gap_clks = 0; tc1 = 0; tc2 = 0;
            end
            prev_vld = vec_vld_o;
        end
    end

    logic [15:0] lfsr = 16'hACE1;
    function automatic logic [15:0] step(input logic [15:0] v);
        return {v[14:0], v[15] ^ v[13] ^ v[12] ^ v[10]};
    endfunction

    task automatic wait_idle();
        for (int i = 0; i < 400; i++) begin
            @(negedge clk);
            lfsr = step(lfsr);
            data_i = lfsr;
            if (m_st == 0 && i > 2) break;
        end
    endtask

    initial begin
        repeat (4) @(negedge clk);
        // R12: reset values while reset is held.
        chk("R12 stat", stat_o, 3);
        chk("R12 inta_n", inta_n_o, 1);
        chk("R12 lock_n", lock_n_o, 1);
        chk("R12 addr_en", addr_en_o, 1);
        chk("R12 vec", vec_o, 0);
        chk("R12 vec_vld", vec_vld_o, 0);
        rst_n = 1'b1;
        run_cmp = 1;
        @(negedge clk);
        chk("R12 lock_n after release", lock_n_o, 1);

        // Ready always high: minimum wait must still be inserted (R8).
        fast_mode = 1;
        rdy_i = 1'b1;
        req_i = 1'b1;
        repeat (2) @(negedge clk);
        req_i = 1'b0;
        wait_idle();
        fast_mode = 0;

        // Random ready, single requests.
        for (int s = 0; s < 6; s++) begin
            req_i = 1'b1;
            repeat (2) @(negedge clk);
            req_i = 1'b0;
            for (int i = 0; i < 300; i++) begin
                @(negedge clk);
                lfsr = step(lfsr);
                data_i = lfsr;
                rdy_i = lfsr[s % 4] | lfsr[7];
                if (m_st == 0) break;
            end
        end

        // Request held high: back-to-back exchanges (R11).
        req_i = 1'b1;
        for (int i = 0; i < 600; i++) begin
            @(negedge clk);
            lfsr = step(lfsr);
            data_i = lfsr;
            rdy_i = lfsr[3] | lfsr[9];
        end

        // Random request pulses while busy (R11), slow ready.
        for (int i = 0; i < 1500; i++) begin
            @(negedge clk);
            lfsr = step(lfsr);
            data_i = lfsr;
            rdy_i = lfsr[2] & lfsr[5];
            req_i = lfsr[11];
        end
        req_i = 1'b0;
        rdy_i = 1'b1;
        wait_idle();
        chk("R6 lock released at end", lock_n_o, 1);

        if (!finished) begin
            finished = 1;
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

    initial begin
        #(5.0 * 150000);
        if (!finished) begin
            finished = 1;
            checks++;
            errors++;
            $display("FAIL watchdog expired actual=hung expected=done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end
endmodule